// File: doc/BRIEF.md
# Fractional microsecond tick counter

This block derives a one-microsecond time base from a faster reference clock and counts elapsed microseconds. The reference rate need not be a whole multiple of 1 MHz. A 16-bit step ratio programmed through a small register port drives a fractional accumulator. The accumulator spreads its tick enables evenly, so the average tick rate is exactly 1 MHz for reference clocks such as 12.8, 16.8, 19.2 or 38.4 MHz.

The tick enable is also brought out on a pin, so other timers in the same clock domain can step on it. Software reads the free-running microsecond count through the register port. It can also freeze the time base, for example while it takes a consistent snapshot of several timers.

Top module: `usec_tick_counter`

## Requirements
- R1: After reset the ratio register reads 0x0000000b, the counter reads 0, the freeze register reads 0 and `tick_o` is low.
- R2: The ratio register sits at offset 0x14 and stores bits 15:0 of a write; bits 31:16 read as zero. Bits 15:8 hold N (ticks per period, minus one) and bits 7:0 hold D (reference cycles per period, minus one).
- R3: While not frozen and with N <= D, every run of D+1 reference cycles that starts right after a ratio write has exactly N+1 tick cycles. A tick is raised in the cycle where the accumulated sum of N+1 steps reaches D+1 or more. For example, 0x043f at 12.8 MHz and 0x000b at 12 MHz each average 1 MHz.
- R4: `tick_o` is high for at most one cycle per reference cycle. When N > D it is high on every unfrozen cycle.
- R5: The counter at offset 0x10 is CNT_W bits wide. It increases by one on the clock edge that ends each tick cycle, changes at no other time, and wraps from all ones to zero.
- R6: The counter is read-only: a write to offset 0x10 leaves its value unchanged.
- R7: Bit 0 of the register at offset 0x4c is the freeze bit. While it is 1, `tick_o` stays low, the counter holds and the accumulator holds. Clearing the bit resumes from the held values.
- R8: A write to the ratio register clears the accumulator. The first tick after the write comes in cycle ceil((D+1)/(N+1)), where the cycle after the write edge counts as cycle 1.
- R9: Reads from any other offset return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wr | input | 1 | Write strobe, taken on the rising edge |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| tick_o | output | 1 | One-cycle microsecond tick enable |

## Verification
The properties assume that every port carries a defined value from the first edge after reset. They also assume that `reg_addr`, `reg_wr` and `reg_wdata` change only between clock edges. Any ratio value is allowed, including N greater than D. The bench always drives its inputs on the falling edge with known values, and its random ratio writes include both N <= D and unconstrained settings. The counter width in the bench is set small, so that wrap-around is reached within the run.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;

    // Register byte offsets; software decodes these.
    localparam int unsigned OFF_COUNT = 32'h10;
    localparam int unsigned OFF_RATIO = 32'h14;
    localparam int unsigned OFF_FREEZE = 32'h4c;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_RATIO,
        SEL_FREEZE
    } reg_sel_e;

endpackage

// File: rtl/usec_regs.sv
module usec_regs
    import usec_tick_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned FIELD_W   = 8,
    parameter int unsigned CNT_W     = 32,
    parameter logic [2*FIELD_W-1:0] RESET_RATIO = 16'h000b
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [CNT_W-1:0]     count,
    output logic [DATA_W-1:0]    rdata,
    output logic [2*FIELD_W-1:0] ratio,
    output logic                 freeze,
    output logic                 ratio_wr
);
    localparam int unsigned RATIO_W = 2 * FIELD_W;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               freeze;
    } regs_t;

    regs_t    st_d, st_q;
    reg_sel_e sel;

    always_comb begin
        if (addr == ADDR_W'(OFF_COUNT)) begin
            sel = SEL_COUNT;
        end else if (addr == ADDR_W'(OFF_RATIO)) begin
            sel = SEL_RATIO;
        end else if (addr == ADDR_W'(OFF_FREEZE)) begin
            sel = SEL_FREEZE;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        st_d     = st_q;
        ratio_wr = 1'b0;
        if (wr) begin
            case (sel)
                SEL_RATIO: begin
                    st_d.ratio = wdata[RATIO_W-1:0];
                    ratio_wr   = 1'b1;
                end
                SEL_FREEZE: st_d.freeze = wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ratio  <= RESET_RATIO;
            st_q.freeze <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_COUNT:  rdata = DATA_W'(count);
            SEL_RATIO:  rdata = DATA_W'(st_q.ratio);
            SEL_FREEZE: rdata = DATA_W'(st_q.freeze);
            default:    rdata = '0;
        endcase
    end

    assign ratio  = st_q.ratio;
    assign freeze = st_q.freeze;

endmodule

// File: rtl/usec_frac_accum.sv
module usec_frac_accum #(
    parameter int unsigned FIELD_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*FIELD_W-1:0] ratio,
    input  logic                 ratio_wr,
    input  logic                 freeze,
    output logic                 tick,
    output logic [FIELD_W:0]     acc
);
    localparam int unsigned ACC_W = FIELD_W + 1;
    localparam int unsigned SUM_W = FIELD_W + 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_t;

    acc_t             st_d, st_q;
    logic [SUM_W-1:0] step;
    logic [SUM_W-1:0] modulus;
    logic [SUM_W-1:0] sum;
    logic             reach;
    logic             saturate;

    always_comb begin
        step     = SUM_W'(ratio[2*FIELD_W-1:FIELD_W]) + SUM_W'(1);
        modulus  = SUM_W'(ratio[FIELD_W-1:0]) + SUM_W'(1);
        sum      = SUM_W'(st_q.acc) + step;
        reach    = (sum >= modulus);
        saturate = (step >= modulus);
        tick     = reach && !freeze;
    end

    always_comb begin
        st_d = st_q;
        if (ratio_wr) begin
            st_d.acc = '0;
        end else if (freeze) begin
            st_d.acc = st_q.acc;
        end else if (saturate) begin
            st_d.acc = '0;
        end else if (reach) begin
            st_d.acc = ACC_W'(sum - modulus);
        end else begin
            st_d.acc = ACC_W'(sum);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.acc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;

endmodule

// File: rtl/usec_count.sv
module usec_count #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             freeze,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick && !freeze) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/usec_tick_counter.sv
module usec_tick_counter #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned FIELD_W = 8,
    parameter int unsigned CNT_W   = 32,
    parameter logic [2*FIELD_W-1:0] RESET_RATIO = 16'h000b
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tick_o
);
    logic [2*FIELD_W-1:0] ratio_w;
    logic                 freeze_w;
    logic                 ratio_wr_w;
    logic [FIELD_W:0]     acc_w;
    logic [CNT_W-1:0]     count_w;

    usec_regs #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .FIELD_W    (FIELD_W),
        .CNT_W      (CNT_W),
        .RESET_RATIO(RESET_RATIO)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .count   (count_w),
        .rdata   (reg_rdata),
        .ratio   (ratio_w),
        .freeze  (freeze_w),
        .ratio_wr(ratio_wr_w)
    );

    usec_frac_accum #(
        .FIELD_W(FIELD_W)
    ) i_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio   (ratio_w),
        .ratio_wr(ratio_wr_w),
        .freeze  (freeze_w),
        .tick    (tick_o),
        .acc     (acc_w)
    );

    usec_count #(
        .CNT_W(CNT_W)
    ) i_count (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_o),
        .freeze(freeze_w),
        .count (count_w)
    );

endmodule

// File: rtl/usec_tick_counter_chk.sv
module usec_tick_counter_chk #(
    parameter int unsigned FIELD_W = 8,
    parameter int unsigned CNT_W   = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_o,
    input logic                 freeze,
    input logic                 ratio_wr,
    input logic [2*FIELD_W-1:0] ratio,
    input logic [FIELD_W:0]     acc,
    input logic [CNT_W-1:0]     count
);
    logic [FIELD_W:0] modulus;
    assign modulus = {1'b0, ratio[FIELD_W-1:0]} + 1'b1;

    // R7
    frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> !tick_o);

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1)));

    // R5
    tick_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> count == CNT_W'($past(count) + 1'b1));

    // R8
    ratio_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_wr |=> acc == '0);

    // R3
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc < modulus);

    // R7
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !ratio_wr) |=> $stable(acc) && $stable(count));

endmodule

bind usec_tick_counter usec_tick_counter_chk #(
    .FIELD_W(FIELD_W),
    .CNT_W  (CNT_W)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_o  (tick_o),
    .freeze  (freeze_w),
    .ratio_wr(ratio_wr_w),
    .ratio   (ratio_w),
    .acc     (acc_w),
    .count   (count_w)
);

// File: tb/test_usec_tick_counter.sv
`timescale 1ns/1ps
module test_usec_tick_counter;
    localparam int unsigned CW = 10;
    localparam int unsigned CMASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usec_tick_counter #(.CNT_W(CW)) i_usec_tick_counter (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_o(tick_o)
    );

    // Reference model, built from the requirements.
    int unsigned m_ratio, m_frz, m_acc, m_cnt;

    function automatic int unsigned f_step();
        return ((m_ratio >> 8) & 255) + 1;
    endfunction
    function automatic int unsigned f_mod();
        return (m_ratio & 255) + 1;
    endfunction
    function automatic bit f_tick();
        return (m_frz == 0) && (m_acc + f_step() >= f_mod());
    endfunction
    function automatic int unsigned f_read(input logic [7:0] a);
        case (a)
            8'h10: return m_cnt;
            8'h14: return m_ratio;
            8'h4c: return m_frz;
            default: return 0;
        endcase
    endfunction
    function automatic string f_tag(input logic [7:0] a);
        case (a)
            8'h10: return "R5";
            8'h14: return "R2";
            8'h4c: return "R7";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ratio = 32'h000b; m_frz = 0; m_acc = 0; m_cnt = 0;
        end else begin
            if (f_tick()) m_cnt = (m_cnt + 1) & CMASK;
            if (m_frz == 0) begin
                if (f_step() >= f_mod()) m_acc = 0;
                else if (m_acc + f_step() >= f_mod()) m_acc = m_acc + f_step() - f_mod();
                else m_acc = m_acc + f_step();
            end
            if (reg_wr && reg_addr == 8'h14) begin
                m_ratio = reg_wdata & 32'hffff; m_acc = 0;
            end
            if (reg_wr && reg_addr == 8'h4c) m_frz = reg_wdata[0];
        end
    end

    task automatic check(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    // One cycle: drive at the falling edge, then compare outputs with the model.
    task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wdata = d;
        #1;
        check("R3", tick_o, f_tick());
        check(f_tag(a), reg_rdata, f_read(a));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(8'h10, 1'b0, '0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        int ticks;
        int first;
        int unsigned held;
        logic [15:0] ex [8] = '{16'h000b, 16'h043f, 16'h000c, 16'h0453,
                                16'h045f, 16'h0019, 16'h04bf, 16'h002f};
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        reg_addr = 8'h14; #1; check("R1", reg_rdata, 32'h0000000b);
        reg_addr = 8'h10; #1; check("R1", reg_rdata, 0);
        reg_addr = 8'h4c; #1; check("R1", reg_rdata, 0);
        check("R1", tick_o, 0);

        // R2 upper bits dropped
        step(8'h14, 1'b1, 32'hdead043f);
        step(8'h14, 1'b0, '0);
        check("R2", reg_rdata, 32'h0000043f);

        // R8 first tick after ratio write: ceil(64/5) = 13
        step(8'h14, 1'b1, 32'h043f);
        first = 0;
        for (int k = 1; k <= 40 && first == 0; k++) begin
            step(8'h10, 1'b0, '0);
            if (tick_o) first = k;
        end
        check("R8", first, 13);

        // R3 each example ratio: 3 periods give 3*(N+1) ticks
        for (int e = 0; e < 8; e++) begin
            step(8'h14, 1'b1, {16'h0, ex[e]});
            ticks = 0;
            for (int k = 0; k < 3 * ((ex[e] & 255) + 1); k++) begin
                step(8'h10, 1'b0, '0);
                ticks += tick_o;
            end
            check("R3", ticks, 3 * ((ex[e] >> 8) + 1));
        end

        // R4 N > D: tick every cycle
        step(8'h14, 1'b1, 32'h0501);
        ticks = 0;
        for (int k = 0; k < 10; k++) begin
            step(8'h10, 1'b0, '0);
            ticks += tick_o;
        end
        check("R4", ticks, 10);

        // R6 counter ignores writes
        step(8'h10, 1'b0, '0);
        held = reg_rdata;
        step(8'h10, 1'b1, 32'hffffffff);
        step(8'h10, 1'b0, '0);
        check("R6", reg_rdata, (held + 2) & CMASK);

        // R7 freeze holds counter and silences tick
        step(8'h4c, 1'b1, 32'h1);
        step(8'h10, 1'b0, '0);
        held = reg_rdata;
        ticks = 0;
        for (int k = 0; k < 20; k++) begin
            step(8'h10, 1'b0, '0);
            ticks += tick_o;
        end
        check("R7", ticks, 0);
        check("R7", reg_rdata, held);
        step(8'h4c, 1'b1, 32'h0);
        step(8'h10, 1'b0, '0);
        step(8'h10, 1'b0, '0);
        check("R7", reg_rdata, (held + 1) & CMASK);

        // R9 unmapped write changes nothing, reads zero
        step(8'h20, 1'b1, 32'hffffffff);
        step(8'h20, 1'b0, '0);
        check("R9", reg_rdata, 0);
        step(8'h14, 1'b0, '0);
        check("R9", reg_rdata, 32'h0501);

        // R5 wrap from all ones to zero, every cycle a tick
        step(8'h14, 1'b1, 32'h0000);
        first = 0;
        for (int k = 0; k < 1100 && first == 0; k++) begin
            step(8'h10, 1'b0, '0);
            if (reg_rdata == CMASK) first = 1;
        end
        step(8'h10, 1'b0, '0);
        check("R5", reg_rdata, 0);

        // Random mix
        for (int k = 0; k < 4000; k++) begin
            int r;
            int unsigned dd, nn;
            logic [7:0] a;
            r = $urandom % 100;
            case ($urandom % 5)
                0: a = 8'h10;
                1: a = 8'h14;
                2: a = 8'h4c;
                3: a = 8'h10;
                default: a = 8'($urandom);
            endcase
            if (r < 2) begin
                dd = $urandom % 256;
                nn = (r == 0) ? $urandom % 256 : $urandom % (dd + 1);
                step(8'h14, 1'b1, $urandom & 32'hffff0000 | (nn << 8) | dd);
            end else if (r < 4) begin
                step(8'h4c, 1'b1, {$urandom} & 32'h1);
            end else if (r < 6) begin
                step(8'h10, 1'b1, $urandom);
            end else if (r < 8) begin
                step(8'($urandom) | 8'h01, 1'b1, $urandom);
            end else begin
                step(a, 1'b0, '0);
            end
        end
        step(8'h4c, 1'b1, 32'h0);
        idle(4);
        done = 1'b1;
        summary();
    end
endmodule